// File: doc/BRIEF.md
# Boot-Aware General-Purpose I/O Port

This block runs a ten-pin general-purpose I/O port for a small embedded controller. Software controls it through a small register interface. Each pin can be an input or an output. An output pin can drive both levels (push-pull), drive only low (open-drain), or drive only high (open-source). Every pad input passes through a two-stage synchroniser before software reads it.

After reset a boot phase is active, and a hardware override takes three pins away from software. Pin 2 becomes an input, and its synchronised level is exported as an active-high upload-enable strap, which is asserted when the pin is low. Pins 0 and 1 become outputs that show a two-bit loader status. Pin 0 is the one to use for a debug LED. Software may write direction and mode bits for these pins during boot. The values are stored but have no effect until the phase ends. The phase ends when `boot_done_i` is seen high, and that release is sticky until reset.

A separate timing output also exists. Configuration bit 7 selects what it carries: either a slot-alignment pulse or the baseband transmit symbol. Each pad is modelled as separate output-enable, output-value and input signals.

Top module: `gpio_boot_port`

## Requirements
- R1: After reset, the direction, output-data, mode and configuration registers read 0, and every pin that boot does not force has output enable low.
- R2: Register map: address 0 is direction (bit i = 1 makes pin i an output), address 1 is output data, address 2 is mode, address 3 is input data, and address 4 is configuration (bits 7:0). Outside boot, a push-pull output pin drives its output-data bit, and an input pin has output enable low.
- R3: Mode field bits [2i+1:2i] select the behaviour of pin i: 0 is push-pull, 1 is open-drain, 2 is open-source, and 3 acts as push-pull. In open-drain mode an output pin drives low when its data bit is 0 and floats when it is 1.
- R4: In open-source mode an output pin drives high when its data bit is 1 and floats when it is 0.
- R5: The input-data register shows each pad level exactly two rising clock edges after it was sampled. Writes to address 3 have no effect.
- R6: While boot is active, pin 2 has output enable low, and `boot_strap_o` is the inverse of the synchronised pin 2 level. Once boot is released, `boot_strap_o` is 0.
- R7: While boot is active, pins 0 and 1 are outputs that drive `boot_stat_i[0]` and `boot_stat_i[1]`.
- R8: In the cycle after the edge that samples `boot_done_i` high, pins 0 to 2 follow the direction, mode and data values that were written during boot.
- R9: Boot release is sticky. Dropping `boot_done_i` afterwards does not bring the override back before the next reset.
- R10: When configuration bit 7 is 0, `timing_o` follows `slot_pulse_i`.
- R11: When configuration bit 7 is 1, `timing_o` follows `tx_space_i`, which is high while a space symbol is sent and low while a mark symbol is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, shared by reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| boot_done_i | input | 1 | Firmware loading is complete |
| boot_stat_i | input | 2 | Loader status shown on pins 0 and 1 |
| boot_strap_o | output | 1 | Upload-enable strap, active high |
| pad_in | input | 10 | Pad input levels |
| pad_oe | output | 10 | Pad output enables |
| pad_out | output | 10 | Pad output values |
| slot_pulse_i | input | 1 | Slot-alignment pulse |
| tx_space_i | input | 1 | Baseband transmit symbol, 1 = space |
| timing_o | output | 1 | Selected timing output |

## Verification
The assertions check four things on every cycle:
- the forced directions of the boot pins,
- that an open-drain pin never drives high and an open-source pin never drives low,
- that the strap is inactive after release, and that release is sticky,
- the two-edge input delay.

The per-clock reference model in the bench covers what only a scenario can show:
- that direction and mode writes made during boot come into effect at the release edge,
- that writes to the input register are ignored,
- the timing output polarity under both configuration settings.

// File: rtl/gpio_boot_port.sv
module gpio_boot_port #(
  parameter int NPIN      = 10,
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int STAT_PIN0 = 0,
  parameter int STAT_PIN1 = 1,
  parameter int STRAP_PIN = 2,
  parameter int SEL_BIT   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            boot_done_i,
  input  logic [1:0]      boot_stat_i,
  output logic            boot_strap_o,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  input  logic            slot_pulse_i,
  input  logic            tx_space_i,
  output logic            timing_o
);
  localparam int MW = 2 * NPIN;
  localparam logic [AW-1:0] A_DIR = 0, A_DOUT = 1, A_MODE = 2, A_DIN = 3, A_CFG = 4;
  localparam logic [1:0] M_OD = 2'd1, M_OS = 2'd2;

  logic [NPIN-1:0] dir_q, dout_q, meta_q, din_q;
  logic [MW-1:0]   mode_q;
  logic [7:0]      cfg_q;
  logic            released_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q      <= '0;
      dout_q     <= '0;
      mode_q     <= '0;
      cfg_q      <= '0;
      released_q <= 1'b0;
      meta_q     <= '0;
      din_q      <= '0;
    end else begin
      meta_q <= pad_in;
      din_q  <= meta_q;
      if (boot_done_i) released_q <= 1'b1;
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q  <= wdata[NPIN-1:0];
          A_DOUT:  dout_q <= wdata[NPIN-1:0];
          A_MODE:  mode_q <= wdata[MW-1:0];
          A_CFG:   cfg_q  <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:   rdata[NPIN-1:0] = dir_q;
      A_DOUT:  rdata[NPIN-1:0] = dout_q;
      A_MODE:  rdata[MW-1:0]   = mode_q;
      A_DIN:   rdata[NPIN-1:0] = din_q;
      A_CFG:   rdata[7:0]      = cfg_q;
      default: ;
    endcase
  end

  wire booting = !released_q;
  assign boot_strap_o = booting & ~din_q[STRAP_PIN];
  assign timing_o     = cfg_q[SEL_BIT] ? tx_space_i : slot_pulse_i;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    wire [1:0] md = mode_q[2*i +: 2];
    logic oe_sw, out_sw;
    always_comb begin
      case (md)
        M_OD:    begin oe_sw = dir_q[i] & ~dout_q[i]; out_sw = 1'b0; end
        M_OS:    begin oe_sw = dir_q[i] &  dout_q[i]; out_sw = 1'b1; end
        default: begin oe_sw = dir_q[i];              out_sw = dir_q[i] & dout_q[i]; end
      endcase
    end
    if (i == STAT_PIN0) begin : g_s0
      assign pad_oe[i]  = booting | oe_sw;
      assign pad_out[i] = booting ? boot_stat_i[0] : out_sw;
    end else if (i == STAT_PIN1) begin : g_s1
      assign pad_oe[i]  = booting | oe_sw;
      assign pad_out[i] = booting ? boot_stat_i[1] : out_sw;
    end else if (i == STRAP_PIN) begin : g_st
      assign pad_oe[i]  = !booting & oe_sw;
      assign pad_out[i] = booting ? 1'b0 : out_sw;
    end else begin : g_norm
      assign pad_oe[i]  = oe_sw;
      assign pad_out[i] = out_sw;
    end

    // R3
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (released_q && md == M_OD) |-> !(pad_oe[i] && pad_out[i]));
    // R4
    os_never_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (released_q && md == M_OS) |-> !(pad_oe[i] && !pad_out[i]));
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R5
  din_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (din_q == $past(pad_in, 2)));
  // R7
  boot_pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> (pad_oe[STAT_PIN0] && pad_oe[STAT_PIN1] && !pad_oe[STRAP_PIN]));
  // R6
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    released_q |-> !boot_strap_o);
  // R9
  release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    released_q |=> released_q);
endmodule

// File: tb/tb_gpio_boot_port.sv
module tb_gpio_boot_port;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic boot_done_i = 0, boot_strap_o, slot_pulse_i = 0, tx_space_i = 0, timing_o;
  logic [1:0] boot_stat_i = 0;
  logic [9:0] pad_in = 0, pad_oe, pad_out;

  gpio_boot_port dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit done_run = 0;

  // reference model state
  logic [9:0]  m_dir = 0, m_dout = 0, m_din = 0;
  logic [19:0] m_mode = 0;
  logic [7:0]  m_cfg = 0;
  bit          m_rel = 0;
  logic [9:0]  m_hist[$];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_dir = 0; m_dout = 0; m_mode = 0; m_cfg = 0; m_rel = 0; m_din = 0;
      m_hist.delete(); m_hist.push_back(10'd0);
    end else begin
      m_hist.push_back(pad_in);
      m_din = m_hist.pop_front();
      if (boot_done_i) m_rel = 1;
      if (wr_en) begin
        if (addr == 0) m_dir = wdata[9:0];
        if (addr == 1) m_dout = wdata[9:0];
        if (addr == 2) m_mode = wdata[19:0];
        if (addr == 4) m_cfg = wdata[7:0];
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      logic [31:0] er;
      for (int i = 0; i < 10; i++) begin
        int md;
        bit eoe, eout;
        string tg;
        md = (m_mode >> (2 * i)) & 3;
        if (!m_rel && i < 2) begin
          eoe = 1; eout = boot_stat_i[i]; tg = "R7";
        end else if (!m_rel && i == 2) begin
          eoe = 0; eout = 0; tg = "R6";
        end else if (md == 1) begin
          eoe = m_dir[i] && !m_dout[i]; eout = 0; tg = "R3";
        end else if (md == 2) begin
          eoe = m_dir[i] && m_dout[i]; eout = 1; tg = "R4";
        end else begin
          eoe = m_dir[i]; eout = m_dir[i] && m_dout[i]; tg = "R2";
        end
        chk(pad_oe[i] === eoe, tg, $sformatf("pad_oe[%0d]", i), pad_oe[i], eoe);
        if (eoe) chk(pad_out[i] === eout, tg, $sformatf("pad_out[%0d]", i), pad_out[i], eout);
      end
      case (addr)
        0: er = {22'd0, m_dir};
        1: er = {22'd0, m_dout};
        2: er = {12'd0, m_mode};
        3: er = {22'd0, m_din};
        4: er = {24'd0, m_cfg};
        default: er = 0;
      endcase
      chk(rdata === er, (addr == 3) ? "R5" : "R2", "rdata", rdata, er);
      chk(boot_strap_o === (!m_rel && !m_din[2]), "R6", "boot_strap_o", boot_strap_o, !m_rel && !m_din[2]);
      chk(timing_o === (m_cfg[7] ? tx_space_i : slot_pulse_i), m_cfg[7] ? "R11" : "R10",
          "timing_o", timing_o, m_cfg[7] ? tx_space_i : slot_pulse_i);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n, bit rnd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rnd) begin
        pad_in = 10'($urandom); slot_pulse_i = 1'($urandom);
        tx_space_i = 1'($urandom); boot_stat_i = 2'($urandom);
        addr = 3'($urandom_range(0, 5));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state read at ports
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a); #1;
      if (a != 3) chk(rdata === 0, "R1", $sformatf("reset reg %0d", a), rdata, 0);
    end
    chk(pad_oe[9:3] === 0, "R1", "reset pad_oe", pad_oe, 0);
    // boot phase: strap and status
    idle(20, 1);
    pad_in[2] = 0; idle(3, 0);
    chk(boot_strap_o === 1, "R6", "strap with pin2 low", boot_strap_o, 1);
    pad_in[2] = 1; idle(3, 0);
    chk(boot_strap_o === 0, "R6", "strap with pin2 high", boot_strap_o, 0);
    // writes during boot: stored, not applied
    wr(0, 32'h3FF);
    wr(1, 32'h002);
    wr(2, 32'h00001 | (32'h2 << 2) | (32'h0 << 4)); // pin0 OD, pin1 OS, pin2 PP
    wr(3, 32'h155);                                  // R5: ignored
    addr = 3;
    idle(4, 0);
    chk(pad_oe[2] === 0, "R8", "pin2 still input during boot", pad_oe[2], 0);
    // R10: slot pulse path
    for (int k = 0; k < 6; k++) begin @(negedge clk); slot_pulse_i = k[0]; end
    wr(4, 32'h80);
    // R11: baseband path
    for (int k = 0; k < 6; k++) begin @(negedge clk); tx_space_i = k[1]; end
    // release
    @(negedge clk); boot_done_i = 1;
    @(negedge clk); boot_done_i = 0; #1;
    chk(pad_oe[0] === 1 && pad_out[0] === 0, "R8", "pin0 OD drives low", {pad_oe[0], pad_out[0]}, 2'b10);
    chk(pad_oe[1] === 1 && pad_out[1] === 1, "R8", "pin1 OS drives high", {pad_oe[1], pad_out[1]}, 2'b11);
    chk(pad_oe[2] === 1 && pad_out[2] === 0, "R8", "pin2 PP output", {pad_oe[2], pad_out[2]}, 2'b10);
    idle(5, 1);
    pad_in[2] = 0; idle(3, 0);
    chk(boot_strap_o === 0, "R9", "strap stays off", boot_strap_o, 0);
    // normal operation with varied patterns
    for (int p = 0; p < 40; p++) begin
      wr(3'($urandom_range(0, 4)), $urandom);
      idle(3, 1);
    end
    wr(2, 32'h55555); idle(4, 1); // all OD
    wr(2, 32'hAAAAA); idle(4, 1); // all OS
    wr(2, 32'hFFFFF); idle(4, 1); // code 3
    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    done_run = 1;
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule